// File: doc/BRIEF.md
# Trapezoidal Step-Pulse Ramp Generator

This block drives a stepper or servo step input with a fixed number of pulses shaped into a trapezoidal speed profile. A single start strobe captures a peak frequency in Hz, a signed pulse count, a ramp duration in milliseconds and a start/end frequency. The pulse rate begins at the start/end frequency and climbs in linear steps once per millisecond until it reaches the peak. It holds the peak while the target is still far away. It then falls again so that the train ends near the start/end frequency just as the last pulse completes.

The direction line follows the sign of the count. The magnitude of the count sets how many pulses are emitted. A count of zero is refused and raises an error flag. If the move is too short to reach the peak, the ramp turns over early and gives a triangular profile.

Pulses come from a phase accumulator that is clocked at a known system frequency `CLK_HZ`. A one-millisecond tick is derived from the same clock. `CLK_HZ` must exceed twice the widest peak limit.

Top module: `trap_pulse_gen`

## Requirements
- R1: A start strobe seen while idle with a nonzero count raises `busy` on the next clock. `busy` stays high until the last pulse falls. Exactly |count| pulses are emitted. `done` is high for exactly one cycle, in the cycle where `busy` first reads low. `pulse_out` is low whenever `busy` is low.
- R2: `dir_out` is 1 for a positive count and 0 for a negative count (two's complement, sign in bit CNT_W-1). It is set in the same cycle that `busy` rises. It does not change while `busy` stays high. No pulse rises before `busy` has been high for at least one cycle.
- R3: A requested peak below 6 Hz runs at 6 Hz. While pulses remain, the ramp-down never goes below the larger of 6 Hz and the start/end frequency.
- R4: With `wide_mode`=1, `peak_hz` is read as a signed 32-bit value. Negative values clamp to 6 Hz, and values above MAX_HZ_WIDE (100,000) clamp to that limit.
- R5: With `wide_mode`=0, only `peak_hz[15:0]` is used, read as unsigned. Values above MAX_HZ_NARROW (32,767) clamp to that limit.
- R6: A start strobe with a zero count sets `err`, leaves `busy` low and emits no pulse. `err` clears at the next accepted start.
- R7: The first millisecond runs at the start/end frequency. On each millisecond tick the frequency rises by (peak − start)/ramp_ms, rounded down, with a minimum of 1. The rise is capped at the peak, and the rate then holds at the peak.
- R8: The block counts the pulses completed while ramping up. Deceleration begins once the remaining count is no greater than that number, and it can begin during the ramp-up itself (triangular move). While decelerating, the frequency falls by the same step on each tick.
- R9: With `zero_base`=1, the start/end frequency is taken as 0 Hz. No pulse can begin before the first millisecond tick.
- R10: A ramp time of 0 runs the whole move at the clamped peak.
- R11: A start strobe while `busy` is high is ignored. The count and direction of the move in progress do not change.
- R12: At constant frequency each pulse is a square wave whose high and low times differ by at most one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, one cycle |
| peak_hz | input | 32 | Requested peak frequency in Hz |
| pulse_cnt | input | CNT_W (32) | Signed pulse count |
| ramp_ms | input | RAMP_W (16) | Ramp-up and ramp-down duration in ms |
| base_hz | input | FREQ_W (17) | Start/end frequency in Hz |
| wide_mode | input | 1 | 1: 32-bit signed peak form, 0: 16-bit form |
| zero_base | input | 1 | 1: start and end at 0 Hz |
| pulse_out | output | 1 | Step pulse train |
| dir_out | output | 1 | Direction, 1 for a positive count |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command had a zero count |

## Verification
The bench builds the block with `CLK_HZ` set to 250,000. A millisecond is then 250 clocks, so ramps of a few ticks, a full trapezoid and a triangular move each finish in a few thousand cycles. The 6 Hz floor, at about 41,667 clocks per period, also fits inside the run. The peak limits keep their default values. Because 100,000 Hz is then a 2.5-clock period and 32,767 Hz is about 7.63 clocks, the two clamps give clearly different spans over 20 pulses. A 1 kHz train divides the clock exactly, which makes the duty-cycle check exact.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DIV  = 3'd1,
        ST_UP   = 3'd2,
        ST_HOLD = 3'd3,
        ST_DOWN = 3'd4
    } tpg_state_e;

    localparam int unsigned TPG_MIN_HZ = 6;

endpackage

// File: rtl/tpg_div.sv
// Serial restoring divider: one quotient bit per clock, N_W clocks per result.
module tpg_div #(
    parameter int N_W = 17,
    parameter int D_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic [N_W-1:0] quotient,
    output logic           valid
);
    localparam int CW = $clog2(N_W + 1);

    typedef struct packed {
        logic [D_W:0]   rem;
        logic [N_W-1:0] quo;
        logic [D_W-1:0] den;
        logic [CW-1:0]  cnt;
        logic           run;
        logic           valid;
    } div_t;

    div_t q, n;
    logic [D_W:0] shifted;
    logic         fits;

    always_comb begin
        n       = q;
        n.valid = 1'b0;
        shifted = {q.rem[D_W-1:0], q.quo[N_W-1]};
        fits    = shifted >= {1'b0, q.den};
        if (go) begin
            n.rem = '0;
            n.quo = dividend;
            n.den = divisor;
            n.cnt = '0;
            n.run = 1'b1;
        end else if (q.run) begin
            n.rem = fits ? (shifted - {1'b0, q.den}) : shifted;
            n.quo = {q.quo[N_W-2:0], fits};
            n.cnt = q.cnt + CW'(1);
            if (q.cnt == CW'(N_W - 1)) begin
                n.run   = 1'b0;
                n.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign quotient = q.quo;
    assign valid    = q.valid;
endmodule

// File: rtl/tpg_nco.sv
// Phase accumulator: adds twice the frequency each clock, wraps at CLK_HZ,
// and toggles the output on every wrap, giving two edges per period.
module tpg_nco #(
    parameter int CLK_HZ = 50_000_000,
    parameter int FREQ_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [FREQ_W-1:0] freq,
    output logic              pulse,
    output logic              fall
);
    localparam int ACC_W = $clog2(CLK_HZ) + 1;
    localparam int SUM_W = ((ACC_W > FREQ_W + 1) ? ACC_W : FREQ_W + 1) + 1;
    localparam logic [SUM_W-1:0] MODULUS = SUM_W'(CLK_HZ);

    typedef struct packed {
        logic [SUM_W-1:0] acc;
        logic             lvl;
    } nco_t;

    nco_t q, n;
    logic [SUM_W-1:0] sum;
    logic             wrap;

    always_comb begin
        sum  = q.acc + (SUM_W'(freq) << 1);
        wrap = sum >= MODULUS;
        n    = q;
        if (run) begin
            n.acc = wrap ? (sum - MODULUS) : sum;
            n.lvl = q.lvl ^ wrap;
        end else begin
            n.acc = '0;
            n.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign pulse = q.lvl;
    assign fall  = run && wrap && q.lvl;
endmodule

// File: rtl/trap_pulse_gen.sv
module trap_pulse_gen
    import tpg_pkg::*;
#(
    parameter int CLK_HZ        = 50_000_000,
    parameter int MAX_HZ_WIDE   = 100_000,
    parameter int MAX_HZ_NARROW = 32_767,
    parameter int CNT_W         = 32,
    parameter int RAMP_W        = 16,
    parameter int FREQ_W        = $clog2(MAX_HZ_WIDE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       peak_hz,
    input  logic [CNT_W-1:0]  pulse_cnt,
    input  logic [RAMP_W-1:0] ramp_ms,
    input  logic [FREQ_W-1:0] base_hz,
    input  logic              wide_mode,
    input  logic              zero_base,
    output logic              pulse_out,
    output logic              dir_out,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int TICK_CYC = CLK_HZ / 1000;
    localparam int TICK_W   = $clog2(TICK_CYC + 1);
    localparam logic [31:0]       MIN32  = 32'(TPG_MIN_HZ);
    localparam logic [31:0]       MAXW32 = 32'(MAX_HZ_WIDE);
    localparam logic [31:0]       MAXN32 = 32'(MAX_HZ_NARROW);
    localparam logic [FREQ_W-1:0] MIN_F  = FREQ_W'(TPG_MIN_HZ);
    localparam logic [FREQ_W-1:0] MAXW_F = FREQ_W'(MAX_HZ_WIDE);
    localparam logic [FREQ_W-1:0] MAXN_F = FREQ_W'(MAX_HZ_NARROW);

    typedef struct packed {
        tpg_state_e        st;
        logic [FREQ_W-1:0] peak;
        logic [FREQ_W-1:0] floor_hz;
        logic [FREQ_W-1:0] step;
        logic [FREQ_W-1:0] freq;
        logic              no_ramp;
        logic [CNT_W-1:0]  total;
        logic [CNT_W-1:0]  emitted;
        logic [CNT_W-1:0]  up_cnt;
        logic [TICK_W-1:0] tick;
        logic              dir;
        logic              busy;
        logic              done;
        logic              err;
    } ctl_t;

    ctl_t q, n;

    // command conditioning
    logic [31:0]       req;
    logic [31:0]       lim;
    logic [FREQ_W-1:0] peak_c;
    logic [FREQ_W-1:0] base_c;
    logic [FREQ_W-1:0] floor_c;
    logic [CNT_W-1:0]  cnt_mag;
    logic              accept;

    always_comb begin
        req = wide_mode ? peak_hz : {16'd0, peak_hz[15:0]};
        lim = wide_mode ? MAXW32 : MAXN32;
        if ((wide_mode && peak_hz[31]) || (req < MIN32)) begin
            peak_c = MIN_F;
        end else if (req > lim) begin
            peak_c = wide_mode ? MAXW_F : MAXN_F;
        end else begin
            peak_c = req[FREQ_W-1:0];
        end
        if (zero_base)             base_c = '0;
        else if (base_hz > peak_c) base_c = peak_c;
        else                       base_c = base_hz;
        floor_c = (base_c < MIN_F) ? MIN_F : base_c;
        cnt_mag = pulse_cnt[CNT_W-1] ? (~pulse_cnt + CNT_W'(1)) : pulse_cnt;
        accept  = start && (q.st == ST_IDLE) && (cnt_mag != '0);
    end

    // step size divider
    logic [FREQ_W-1:0] quo;
    logic              quo_valid;

    tpg_div #(
        .N_W (FREQ_W),
        .D_W (RAMP_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (accept),
        .dividend (peak_c - base_c),
        .divisor  (ramp_ms),
        .quotient (quo),
        .valid    (quo_valid)
    );

    // pulse synthesis
    logic nco_run;
    logic nco_pulse;
    logic nco_fall;

    assign nco_run = (q.st == ST_UP) || (q.st == ST_HOLD) || (q.st == ST_DOWN);

    tpg_nco #(
        .CLK_HZ (CLK_HZ),
        .FREQ_W (FREQ_W)
    ) u_nco (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (nco_run),
        .freq  (q.freq),
        .pulse (nco_pulse),
        .fall  (nco_fall)
    );

    // profile sequencing
    logic              tick_hit;
    logic [CNT_W-1:0]  emitted_nx;
    logic [CNT_W-1:0]  up_nx;
    logic [CNT_W-1:0]  rem_nx;
    logic [FREQ_W:0]   up_sum;
    logic [FREQ_W:0]   down_lim;

    always_comb begin
        n          = q;
        n.done     = 1'b0;
        tick_hit   = (q.tick == TICK_W'(TICK_CYC - 1));
        emitted_nx = q.emitted + CNT_W'(1);
        up_nx      = q.up_cnt + {{(CNT_W-1){1'b0}}, (q.st == ST_UP)};
        rem_nx     = q.total - emitted_nx;
        up_sum     = {1'b0, q.freq} + {1'b0, q.step};
        down_lim   = {1'b0, q.floor_hz} + {1'b0, q.step};

        unique case (q.st)
            ST_IDLE: begin
                if (start && cnt_mag == '0) begin
                    n.err = 1'b1;
                end else if (accept) begin
                    n.err      = 1'b0;
                    n.busy     = 1'b1;
                    n.dir      = ~pulse_cnt[CNT_W-1];
                    n.peak     = peak_c;
                    n.floor_hz = floor_c;
                    n.total    = cnt_mag;
                    n.emitted  = '0;
                    n.up_cnt   = '0;
                    n.no_ramp  = (ramp_ms == '0);
                    n.freq     = (ramp_ms == '0) ? peak_c : base_c;
                    n.st       = ST_DIV;
                end
            end
            ST_DIV: begin
                if (quo_valid) begin
                    if (q.no_ramp)        n.step = '0;
                    else if (quo == '0)   n.step = FREQ_W'(1);
                    else                  n.step = quo;
                    n.tick = '0;
                    n.st   = q.no_ramp ? ST_HOLD : ST_UP;
                end
            end
            ST_UP, ST_HOLD, ST_DOWN: begin
                n.tick = tick_hit ? '0 : (q.tick + TICK_W'(1));
                if (nco_fall) begin
                    n.emitted = emitted_nx;
                    n.up_cnt  = up_nx;
                end
                if (nco_fall && emitted_nx == q.total) begin
                    n.st   = ST_IDLE;
                    n.busy = 1'b0;
                    n.done = 1'b1;
                end else if (q.st == ST_UP) begin
                    if (nco_fall && rem_nx <= up_nx) begin
                        n.st   = ST_DOWN;
                        n.freq = (q.freq < q.floor_hz) ? q.floor_hz : q.freq;
                    end else if (tick_hit) begin
                        if (up_sum >= {1'b0, q.peak}) begin
                            n.freq = q.peak;
                            n.st   = ST_HOLD;
                        end else begin
                            n.freq = up_sum[FREQ_W-1:0];
                        end
                    end
                end else if (q.st == ST_HOLD) begin
                    if (nco_fall && rem_nx <= q.up_cnt) begin
                        n.st = ST_DOWN;
                    end
                end else begin
                    if (tick_hit) begin
                        if ({1'b0, q.freq} > down_lim) n.freq = q.freq - q.step;
                        else                           n.freq = q.floor_hz;
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign pulse_out = nco_pulse;
    assign dir_out   = q.dir;
    assign busy      = q.busy;
    assign done      = q.done;
    assign err       = q.err;
endmodule

// File: rtl/tpg_chk.sv
module tpg_chk (
    input logic clk,
    input logic rst_n,
    input logic pulse_out,
    input logic dir_out,
    input logic busy,
    input logic done,
    input logic err
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
    AST_DONE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pulse_out); // R1
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dir_out)); // R2
    AST_DIR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(busy)); // R2
    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy); // R6
endmodule

bind trap_pulse_gen tpg_chk u_tpg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_out (pulse_out),
    .dir_out   (dir_out),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/tb_trap_pulse_gen.sv
module tb_trap_pulse_gen;
    localparam int CLK_HZ = 250_000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] peak_hz;
    logic [31:0] pulse_cnt;
    logic [15:0] ramp_ms;
    logic [16:0] base_hz;
    logic        wide_mode;
    logic        zero_base;
    logic        pulse_out, dir_out, busy, done, err;

    always #4 clk = ~clk;

    trap_pulse_gen #(.CLK_HZ(CLK_HZ)) dut (
        .clk (clk), .rst_n (rst_n), .start (start), .peak_hz (peak_hz),
        .pulse_cnt (pulse_cnt), .ramp_ms (ramp_ms), .base_hz (base_hz),
        .wide_mode (wide_mode), .zero_base (zero_base), .pulse_out (pulse_out),
        .dir_out (dir_out), .busy (busy), .done (done), .err (err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // per-run observations
    int s_rise, s_first, s_span, s_minper, s_lastper, s_hi, s_lo;
    int s_done, s_dirbad, s_busybad;
    logic s_dir0, s_err0, s_busy0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] pk, input logic [31:0] cnt, input logic [15:0] rm,
                         input logic [16:0] bs, input logic wide, input logic zb);
        @(negedge clk);
        peak_hz = pk; pulse_cnt = cnt; ramp_ms = rm; base_hz = bs;
        wide_mode = wide; zero_base = zb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic observe(input int limit, input int inj_at);
        int   last_rise;
        int   first_fall;
        logic pp;
        bit   seen;
        s_rise = 0; s_first = -1; s_span = 0; s_minper = 1 << 30; s_lastper = 0;
        s_hi = -1; s_lo = -1; s_done = 0; s_dirbad = 0; s_busybad = 0;
        s_dir0 = dir_out; s_err0 = err; s_busy0 = busy;
        last_rise = -1; first_fall = -1; pp = pulse_out; seen = 0;
        for (int t = 0; t < limit; t++) begin
            if (pulse_out && !pp) begin
                if (s_rise == 0) s_first = t;
                else begin
                    if (t - last_rise < s_minper) s_minper = t - last_rise;
                    s_lastper = t - last_rise;
                end
                if (s_rise == 1) s_lo = t - first_fall;
                last_rise = t;
                s_rise++;
            end
            if (!pulse_out && pp && first_fall < 0) begin
                first_fall = t;
                s_hi = t - s_first;
            end
            if (busy && dir_out !== s_dir0) s_dirbad++;
            if (done && busy) s_busybad++;
            if (seen && !done) break;
            if (done) begin s_done++; seen = 1; end
            if (t == inj_at) begin start = 1'b1; pulse_cnt = -32'sd5; end
            else if (t == inj_at + 1) start = 1'b0;
            pp = pulse_out;
            @(negedge clk);
        end
        s_span = last_rise - s_first;
    endtask

    task automatic t_reset;
        chk(busy == 0 && done == 0 && err == 0 && pulse_out == 0, "R1 reset outputs idle",
            {busy, done, err, pulse_out}, 0);
    endtask

    task automatic t_trapezoid;
        issue(32'd5000, 32'd60, 16'd4, 17'd1000, 1'b1, 1'b0);
        observe(20000, -10);
        chk(s_busy0 == 1, "R1 busy after strobe", s_busy0, 1);
        chk(s_rise == 60, "R1 pulse count", s_rise, 60);
        chk(s_done == 1 && s_busybad == 0, "R1 done one cycle busy low", s_done, 1);
        chk(s_dir0 == 1 && s_dirbad == 0, "R2 positive direction held", s_dirbad, 0);
        chk(s_first >= 130 && s_first <= 170, "R7 first pulse at start freq", s_first, 145);
        chk(s_minper >= 48 && s_minper <= 52, "R7 holds peak period", s_minper, 50);
        chk(s_lastper > 60, "R8 decelerates at end", s_lastper, 83);
    endtask

    task automatic t_triangle;
        issue(32'd5000, -32'sd6, 16'd4, 17'd1000, 1'b1, 1'b0);
        observe(20000, -10);
        chk(s_rise == 6, "R8 triangular count", s_rise, 6);
        chk(s_minper > 70, "R8 peak never reached", s_minper, 125);
        chk(s_dir0 == 0 && s_dirbad == 0, "R2 negative direction held", s_dir0, 0);
    endtask

    task automatic t_wide_cap;
        issue(32'd500000, 32'd20, 16'd0, 17'd0, 1'b1, 1'b0);
        observe(5000, -10);
        chk(s_span >= 46 && s_span <= 49, "R4 wide cap 100000 Hz span", s_span, 47);
        chk(s_rise == 20, "R10 no-ramp count", s_rise, 20);
    endtask

    task automatic t_wide_neg;
        issue(32'hFFFF_0000, 32'd2, 16'd0, 17'd0, 1'b1, 1'b0);
        observe(100000, -10);
        chk(s_hi >= 20832 && s_hi <= 20835, "R4 negative peak clamps to 6 Hz", s_hi, 20833);
    endtask

    task automatic t_narrow_cap;
        issue(32'hABCD_9C40, 32'd20, 16'd0, 17'd0, 1'b0, 1'b0);
        observe(5000, -10);
        chk(s_span >= 143 && s_span <= 147, "R5 narrow cap 32767 Hz span", s_span, 145);
    endtask

    task automatic t_min_clamp;
        issue(32'd3, 32'd1, 16'd0, 17'd0, 1'b1, 1'b1);
        observe(50000, -10);
        chk(s_hi >= 20832 && s_hi <= 20835, "R3 6 Hz floor half period", s_hi, 20833);
        chk(s_rise == 1 && s_done == 1, "R3 single pulse completes", s_rise, 1);
    endtask

    task automatic t_duty;
        issue(32'd1000, 32'd3, 16'd0, 17'd0, 1'b1, 1'b0);
        observe(5000, -10);
        chk(s_hi >= 124 && s_hi <= 126, "R12 high time", s_hi, 125);
        chk((s_hi - s_lo) <= 1 && (s_lo - s_hi) <= 1, "R12 high equals low", s_lo, s_hi);
    endtask

    task automatic t_zero_count;
        issue(32'd5000, 32'd0, 16'd2, 17'd1000, 1'b1, 1'b0);
        observe(300, -10);
        chk(s_err0 == 1 && s_busy0 == 0, "R6 zero count flagged", {s_err0, s_busy0}, 2);
        chk(s_rise == 0, "R6 no pulses on zero count", s_rise, 0);
    endtask

    task automatic t_zero_base;
        issue(32'd5000, 32'd10, 16'd2, 17'd3000, 1'b1, 1'b1);
        observe(20000, -10);
        chk(s_err0 == 0, "R6 err cleared by next start", s_err0, 0);
        chk(s_first >= 250 && s_first <= 420, "R9 no pulse in first ms", s_first, 320);
        chk(s_rise == 10, "R9 count from zero base", s_rise, 10);
    endtask

    task automatic t_ignore;
        issue(32'd5000, 32'd30, 16'd0, 17'd0, 1'b1, 1'b0);
        observe(20000, 50);
        chk(s_rise == 30, "R11 count unchanged by restart", s_rise, 30);
        chk(s_dirbad == 0 && dir_out == 1, "R11 direction unchanged", dir_out, 1);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; peak_hz = '0; pulse_cnt = '0; ramp_ms = '0;
        base_hz = '0; wide_mode = 1'b0; zero_base = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_trapezoid();
        t_triangle();
        t_wide_cap();
        t_narrow_cap();
        t_duty();
        t_zero_count();
        t_zero_base();
        t_ignore();
        t_min_clamp();
        t_wide_neg();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule